// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two buses, A and B, through a set of byte-wide sections. Each section carries two banks of data latches, one for A-to-B traffic and one for B-to-A traffic. Each direction of each section has three active-low controls: a chip enable, a latch enable and an output enable. The sections run on their own. Tying their controls together turns the block into one transceiver of full width.

The latches are level-sensitive in function and are built as registers sampled on `clk`. A latch is open while its chip enable and its latch enable are both low. While it is open, its output side follows the input side combinationally, and the register picks up the input at every rising clock edge. Once the latch closes, because the latch enable or the chip enable goes high, the register keeps the value it took at the last rising edge at which it was open.

Tri-state pads are replaced by a data vector plus one drive-enable bit per section on each side, so an outer harness can resolve the shared wires. A per-section flag reports when both directions drive and both latches are open, which would close a loop through the external bus.

Top module: `bus_xcvr`

## Requirements
- R1: Each section (bits `s*8 +: 8` with default parameters) responds only to its own control bits at index `s`. Data of one section never appears in another section's slice.
- R2: `b_drive[s]` is 1 exactly when `ab_ce_n[s]` and `ab_oe_n[s]` are both 0. `a_drive[s]` is 1 exactly when `ba_ce_n[s]` and `ba_oe_n[s]` are both 0.
- R3: When `ab_ce_n[s]` and `ab_le_n[s]` are both 0, the latch is open. The `b_out` slice then equals the `a_in` slice in the same cycle, and the latch stores `a_in` at each rising clock edge.
- R4: When `ab_ce_n[s]` is 0 and `ab_le_n[s]` is 1, the latch holds. The `b_out` slice shows the value stored at the last rising edge at which the latch was open, whatever `a_in` does.
- R5: When `ab_ce_n[s]` is 1, the latch holds even if `ab_le_n[s]` is 0.
- R6: The B-to-A path follows R3 to R5 with `ba_ce_n`, `ba_le_n`, `b_in` and `a_out`.
- R7: `rst` high at a rising edge clears every latch to zero.
- R8: `loop_flag[s]` is 1 exactly when both latches of section `s` are open and both of its drive-enable bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the latch registers |
| rst | input | 1 | Synchronous active-high clear |
| a_in | input | 16 | Value seen on bus A |
| b_in | input | 16 | Value seen on bus B |
| ab_ce_n | input | 2 | A-to-B chip enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_ce_n | input | 2 | B-to-A chip enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |
| b_out | output | 16 | Value offered to bus B |
| b_drive | output | 2 | Per-section drive enable for bus B |
| a_out | output | 16 | Value offered to bus A |
| a_drive | output | 2 | Per-section drive enable for bus A |
| loop_flag | output | 2 | Per-section loop warning |

## Verification
The output vectors show the stored value whenever a latch is closed. A wrongly captured or corrupted latch therefore appears on the matching output slice in the first cycle after capture in which that latch is closed. It does not wait for the output enable. A missed capture while open stays hidden until the latch closes, so the sweep closes every latch many times after an open cycle. Every combination of the six controls per section is driven, with changing data, to expose errors in gating and holding.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_PASS  = 2'd1,
        MODE_CLEAR = 2'd2
    } latch_mode_e;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import bus_xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] din,
    input  logic              ce_n,
    input  logic              le_n,
    input  logic              oe_n,
    output logic [LANE_W-1:0] dout,
    output logic              drive,
    output logic              open_o
);
    typedef struct packed {
        logic [LANE_W-1:0] store;
    } lane_state_t;

    lane_state_t st_d, st_q;
    latch_mode_e mode;
    logic        open_c;

    always_comb begin
        open_c = !ce_n && !le_n;
        if (rst)         mode = MODE_CLEAR;
        else if (open_c) mode = MODE_PASS;
        else             mode = MODE_HOLD;
        st_d = st_q;
        unique case (mode)
            MODE_CLEAR: st_d.store = '0;
            MODE_PASS:  st_d.store = din;
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout   = open_c ? din : st_q.store;
    assign drive  = !ce_n && !oe_n;
    assign open_o = open_c;

    // R3: an open latch captures its input at the edge
    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !le_n) |=> (st_q.store == $past(din)));
    // R4: a closed latch keeps its contents
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && le_n) |=> $stable(st_q.store));
    // R5: chip enable high freezes the latch regardless of latch enable
    assert_ce_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(st_q.store));
    // R7: reset clears the latch
    assert_clear_R7: assert property (@(posedge clk)
        rst |=> (st_q.store == '0));
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_W-1:0] a_in,
    input  logic [SEC_W-1:0] b_in,
    input  logic             ab_ce_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_ce_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n,
    output logic [SEC_W-1:0] b_out,
    output logic             b_drive,
    output logic [SEC_W-1:0] a_out,
    output logic             a_drive,
    output logic             loop_flag
);
    logic ab_open, ba_open;

    xcvr_lane #(.LANE_W(SEC_W)) u_ab (
        .clk(clk), .rst(rst), .din(a_in),
        .ce_n(ab_ce_n), .le_n(ab_le_n), .oe_n(ab_oe_n),
        .dout(b_out), .drive(b_drive), .open_o(ab_open)
    );

    xcvr_lane #(.LANE_W(SEC_W)) u_ba (
        .clk(clk), .rst(rst), .din(b_in),
        .ce_n(ba_ce_n), .le_n(ba_le_n), .oe_n(ba_oe_n),
        .dout(a_out), .drive(a_drive), .open_o(ba_open)
    );

    assign loop_flag = ab_open && ba_open && b_drive && a_drive;

    // R8: a raised loop flag implies both sides are being driven
    assert_loop_drive_R8: assert property (@(posedge clk) disable iff (rst)
        loop_flag |-> (a_drive && b_drive));
    // R3: an open and driven A-to-B lane passes A straight to B
    assert_pass_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (ab_open && b_drive) |-> (b_out == a_in));
    // R6: same for the B-to-A lane
    assert_pass_ba_R6: assert property (@(posedge clk) disable iff (rst)
        (ba_open && a_drive) |-> (a_out == b_in));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int SECTIONS = 2,
    parameter int SEC_W    = 8,
    localparam int BUS_W   = SECTIONS * SEC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BUS_W-1:0]    a_in,
    input  logic [BUS_W-1:0]    b_in,
    input  logic [SECTIONS-1:0] ab_ce_n,
    input  logic [SECTIONS-1:0] ab_le_n,
    input  logic [SECTIONS-1:0] ab_oe_n,
    input  logic [SECTIONS-1:0] ba_ce_n,
    input  logic [SECTIONS-1:0] ba_le_n,
    input  logic [SECTIONS-1:0] ba_oe_n,
    output logic [BUS_W-1:0]    b_out,
    output logic [SECTIONS-1:0] b_drive,
    output logic [BUS_W-1:0]    a_out,
    output logic [SECTIONS-1:0] a_drive,
    output logic [SECTIONS-1:0] loop_flag
);
    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        xcvr_section #(.SEC_W(SEC_W)) u_sec (
            .clk(clk), .rst(rst),
            .a_in(a_in[s*SEC_W +: SEC_W]),
            .b_in(b_in[s*SEC_W +: SEC_W]),
            .ab_ce_n(ab_ce_n[s]), .ab_le_n(ab_le_n[s]), .ab_oe_n(ab_oe_n[s]),
            .ba_ce_n(ba_ce_n[s]), .ba_le_n(ba_le_n[s]), .ba_oe_n(ba_oe_n[s]),
            .b_out(b_out[s*SEC_W +: SEC_W]), .b_drive(b_drive[s]),
            .a_out(a_out[s*SEC_W +: SEC_W]), .a_drive(a_drive[s]),
            .loop_flag(loop_flag[s])
        );

        // R2: output drive on either side follows its own section's enables only
        assert_b_hiz_R2: assert property (@(posedge clk) disable iff (rst)
            (ab_ce_n[s] || ab_oe_n[s]) |-> !b_drive[s]);
        assert_a_hiz_R2: assert property (@(posedge clk) disable iff (rst)
            (ba_ce_n[s] || ba_oe_n[s]) |-> !a_drive[s]);
    end
endmodule

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
module bus_xcvr_bench;
    localparam int SECTIONS = 2;
    localparam int SEC_W    = 8;
    localparam int BUS_W    = SECTIONS * SEC_W;

    logic clk = 1'b0;
    logic rst;
    logic [BUS_W-1:0]    a_in, b_in;
    logic [SECTIONS-1:0] ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
    logic [BUS_W-1:0]    b_out, a_out;
    logic [SECTIONS-1:0] b_drive, a_drive, loop_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [SEC_W-1:0] m_ab [SECTIONS];
    logic [SEC_W-1:0] m_ba [SECTIONS];

    always #2 clk = ~clk;

    bus_xcvr #(.SECTIONS(SECTIONS), .SEC_W(SEC_W)) u_bus_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
        .loop_flag(loop_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int s = 0; s < SECTIONS; s++) begin
            logic ab_op, ba_op, ab_dr, ba_dr;
            logic [SEC_W-1:0] e_b, e_a;
            string tb_tag, ta_tag;
            ab_op = !ab_ce_n[s] && !ab_le_n[s];
            ba_op = !ba_ce_n[s] && !ba_le_n[s];
            ab_dr = !ab_ce_n[s] && !ab_oe_n[s];
            ba_dr = !ba_ce_n[s] && !ba_oe_n[s];
            e_b = ab_op ? a_in[s*SEC_W +: SEC_W] : m_ab[s];
            e_a = ba_op ? b_in[s*SEC_W +: SEC_W] : m_ba[s];
            tb_tag = ab_op ? "R3" : (ab_ce_n[s] ? "R5" : "R4");
            ta_tag = "R6";
            check(tb_tag, 32'(b_out[s*SEC_W +: SEC_W]), 32'(e_b));
            check(ta_tag, 32'(a_out[s*SEC_W +: SEC_W]), 32'(e_a));
            check("R2", 32'(b_drive[s]), 32'(ab_dr));
            check("R2", 32'(a_drive[s]), 32'(ba_dr));
            check("R8", 32'(loop_flag[s]), 32'(ab_op && ba_op && ab_dr && ba_dr));
        end
    endtask

    task automatic clock_model();
        @(posedge clk);
        for (int s = 0; s < SECTIONS; s++) begin
            if (rst) begin
                m_ab[s] = '0;
                m_ba[s] = '0;
            end else begin
                if (!ab_ce_n[s] && !ab_le_n[s]) m_ab[s] = a_in[s*SEC_W +: SEC_W];
                if (!ba_ce_n[s] && !ba_le_n[s]) m_ba[s] = b_in[s*SEC_W +: SEC_W];
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        ab_ce_n = '1; ab_le_n = '0; ab_oe_n = '1;
        ba_ce_n = '1; ba_le_n = '0; ba_oe_n = '1;
        for (int k = 0; k < 3; k++) clock_model();
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: after reset the closed latches show zero
        check("R7", 32'(b_out), 32'h0);
        check("R7", 32'(a_out), 32'h0);

        // exhaustive sweep over both sections' six controls
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] c;
            @(negedge clk);
            c = 12'(i * 1375 + 3);
            a_in = 16'(i * 40503 + 7);
            b_in = 16'(i * 9973) ^ 16'h5A5A;
            rst = ((i % 512) == 300);
            ab_ce_n = {c[6], c[0]};
            ab_le_n = {c[7], c[1]};
            ab_oe_n = {c[8], c[2]};
            ba_ce_n = {c[9], c[3]};
            ba_le_n = {c[10], c[4]};
            ba_oe_n = {c[11], c[5]};
            #1;
            check_all();
            clock_model();
        end

        // R7: reset seen in the previous cycle shows zeros once closed
        @(negedge clk);
        rst = 1'b1;
        clock_model();
        @(negedge clk);
        rst = 1'b0;
        ab_ce_n = '0; ab_le_n = '1; ab_oe_n = '0;
        ba_ce_n = '0; ba_le_n = '1; ba_oe_n = '0;
        #1;
        check("R7", 32'(b_out), 32'h0);
        check("R7", 32'(a_out), 32'h0);

        // R1: section 0 open, section 1 holding
        clock_model();
        @(negedge clk);
        ab_le_n = 2'b10;
        a_in = 16'hC3A5;
        #1;
        check("R1", 32'(b_out[7:0]), 32'hA5);
        check("R1", 32'(b_out[15:8]), 32'h00);
        clock_model();
        @(negedge clk);
        ab_le_n = 2'b11;
        a_in = 16'h0000;
        #1;
        check("R1", 32'(b_out), 32'h00A5);

        // R5: chip enable high with latch enable low ignores new data
        @(negedge clk);
        ab_ce_n = 2'b11; ab_le_n = 2'b00;
        a_in = 16'h7E7E;
        clock_model();
        @(negedge clk);
        ab_ce_n = 2'b00; ab_le_n = 2'b11;
        #1;
        check("R5", 32'(b_out), 32'h00A5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule